// File: doc/BRIEF.md
# YCbCr to RGB Pixel Converter

A streaming colour-space converter. Every accepted beat carries one luma sample and one sample of each chroma component, all 8-bit unsigned. The block turns the beat into one packed 32-bit RGB word. Both chroma samples are re-centred around zero. They are scaled by fixed signed integer coefficients with round-half-up arithmetic shifts, added to luma and clamped to a byte. The three colour bytes are then placed into byte lanes according to a layout code.

The input and output are valid/ready streams. The internal pipeline has three register stages and accepts one beat per cycle while the output is drained. A single stall signal freezes all stages whenever the output holds a word that the sink does not take. The layout code is a static setting. It is taken into the block only while no beat is in flight, so a change made mid-stream cannot split a frame across two layouts.

Byte lane k of `out_pix` means bits [8k+7:8k].

Top module: `ycc2rgb_conv`

## Requirements
- R1: Each chroma sample has 128 subtracted before any multiplication, so an input with both chroma samples at 128 gives R = G = B = Y (Y=100 in layout 0 gives 0x00646464).
- R2: Red equals Y + ((Cr'·22971 + 2^13) >>> 14), where Cr' = Cr − 128. For example, Y=0, Cb=128, Cr=255 in layout 0 gives 0x000000B2.
- R3: Green equals Y + ((Cb'·(−11277) + Cr'·(−23401) + 2^14) >>> 15), where Cb' = Cb − 128. For example, Y=0, Cb=0, Cr=0 in layout 0 gives 0x00008700.
- R4: Blue equals Y + ((Cb'·29033 + 2^13) >>> 14). For example, Y=0, Cb=255, Cr=128 in layout 0 gives 0x00E10000.
- R5: Each channel sum saturates to 0..255. For example, Y=255, Cb=128, Cr=255 in layout 0 gives 0x00FFA4FF.
- R6: Layout codes 2 to 5 are 32-bit and put 0xFF in the one lane not used by a colour. Code 2 puts R,G,B in lanes 0,1,2. Code 3 puts them in lanes 2,1,0. Code 4 puts them in lanes 3,2,1. Code 5 puts them in lanes 1,2,3. Codes 6 and 7 behave as code 2.
- R7: Layout codes 0 and 1 are 24-bit. Code 0 puts R,G,B in lanes 0,1,2 and code 1 puts them in lanes 2,1,0. Lane 3 is 0x00 in both.
- R8: A beat accepted on rising edge n appears on `out_valid`/`out_pix` after rising edge n+2. With `out_ready` high, one beat is accepted every cycle and outputs stay in input order.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and on the next cycle `out_valid` stays high with `out_pix` unchanged.
- R10: `fmt_sel` is captured only on edges where the pipeline holds no beat. A change made while beats are in flight does not alter those beats.
- R11: During and after reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Output layout code (0 to 7) |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Converter can take a beat |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the output word |
| out_pix | output | 32 | Packed pixel; byte lane k is bits [8k+7:8k] |

## Verification
A beat accepted on one rising edge shows up at the output two edges later. Its expected word is therefore computed when the input handshake is seen and queued in order. It is compared at the first output handshake, so neither the latency nor stalls move the comparison point. A separate test steps one beat through an empty pipeline and samples `out_valid` after each of the three edges to pin the latency exactly. Stall checks compare `out_pix` in the cycle after a refused word with the word seen in the cycle before. All sampling is done half a cycle after the active edge, once the registered outputs are stable.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;

    localparam int PIXW     = 8;
    localparam int FMTW     = 3;
    localparam int ACCW     = 32;
    localparam int OFFW     = 16;
    localparam int SHIFT_RB = 14;
    localparam int SHIFT_G  = 15;
    localparam int CHROMA_MID = 128;

    localparam logic signed [ACCW-1:0] K_CR_TO_R = ACCW'(22971);
    localparam logic signed [ACCW-1:0] K_CB_TO_G = ACCW'(-11277);
    localparam logic signed [ACCW-1:0] K_CR_TO_G = ACCW'(-23401);
    localparam logic signed [ACCW-1:0] K_CB_TO_B = ACCW'(29033);

    typedef enum logic [FMTW-1:0] {
        FMT_RGB24 = 3'd0,
        FMT_BGR24 = 3'd1,
        FMT_RGBX  = 3'd2,
        FMT_BGRX  = 3'd3,
        FMT_XBGR  = 3'd4,
        FMT_XRGB  = 3'd5
    } fmt_e;

    typedef enum logic [2:0] {
        SRC_R    = 3'd0,
        SRC_G    = 3'd1,
        SRC_B    = 3'd2,
        SRC_FILL = 3'd3,
        SRC_ZERO = 3'd4
    } src_e;

    // Which colour lands in a given byte lane for a given layout code.
    function automatic src_e lane_src(input logic [FMTW-1:0] fmt, input int lane);
        src_e s;
        s = SRC_ZERO;
        case (fmt)
            FMT_RGB24: s = (lane == 0) ? SRC_R : (lane == 1) ? SRC_G : (lane == 2) ? SRC_B : SRC_ZERO;
            FMT_BGR24: s = (lane == 0) ? SRC_B : (lane == 1) ? SRC_G : (lane == 2) ? SRC_R : SRC_ZERO;
            FMT_BGRX:  s = (lane == 0) ? SRC_B : (lane == 1) ? SRC_G : (lane == 2) ? SRC_R : SRC_FILL;
            FMT_XBGR:  s = (lane == 0) ? SRC_FILL : (lane == 1) ? SRC_B : (lane == 2) ? SRC_G : SRC_R;
            FMT_XRGB:  s = (lane == 0) ? SRC_FILL : (lane == 1) ? SRC_R : (lane == 2) ? SRC_G : SRC_B;
            default:   s = (lane == 0) ? SRC_R : (lane == 1) ? SRC_G : (lane == 2) ? SRC_B : SRC_FILL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ycc_bias_stage.sv
module ycc_bias_stage
    import ycc2rgb_pkg::*;
#(
    parameter int PIX_W = PIXW,
    parameter int MID   = CHROMA_MID
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv_i,
    input  logic                    valid_i,
    input  logic [PIX_W-1:0]        y_i,
    input  logic [PIX_W-1:0]        cb_i,
    input  logic [PIX_W-1:0]        cr_i,
    output logic                    valid_o,
    output logic [PIX_W-1:0]        y_o,
    output logic signed [PIX_W:0]   cbs_o,
    output logic signed [PIX_W:0]   crs_o
);
    localparam int CW = PIX_W + 1;
    localparam logic [CW-1:0] BIAS = CW'(MID);

    typedef struct packed {
        logic                  valid;
        logic [PIX_W-1:0]      y;
        logic signed [CW-1:0]  cbs;
        logic signed [CW-1:0]  crs;
    } bias_t;

    bias_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.valid = valid_i;
            st_d.y     = y_i;
            st_d.cbs   = $signed({1'b0, cb_i} - BIAS);
            st_d.crs   = $signed({1'b0, cr_i} - BIAS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign y_o     = st_q.y;
    assign cbs_o   = st_q.cbs;
    assign crs_o   = st_q.crs;

endmodule

// File: rtl/ycc_mac_stage.sv
module ycc_mac_stage
    import ycc2rgb_pkg::*;
#(
    parameter int PIX_W = PIXW,
    parameter int ACC_W = ACCW,
    parameter int OFF_W = OFFW,
    parameter int SH_RB = SHIFT_RB,
    parameter int SH_G  = SHIFT_G
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv_i,
    input  logic                    valid_i,
    input  logic [PIX_W-1:0]        y_i,
    input  logic signed [PIX_W:0]   cbs_i,
    input  logic signed [PIX_W:0]   crs_i,
    output logic                    valid_o,
    output logic [PIX_W-1:0]        y_o,
    output logic signed [OFF_W-1:0] r_off_o,
    output logic signed [OFF_W-1:0] g_off_o,
    output logic signed [OFF_W-1:0] b_off_o
);
    localparam logic signed [ACC_W-1:0] HALF_RB = ACC_W'(1) << (SH_RB - 1);
    localparam logic signed [ACC_W-1:0] HALF_G  = ACC_W'(1) << (SH_G - 1);

    typedef struct packed {
        logic                   valid;
        logic [PIX_W-1:0]       y;
        logic signed [OFF_W-1:0] r_off;
        logic signed [OFF_W-1:0] g_off;
        logic signed [OFF_W-1:0] b_off;
    } mac_t;

    mac_t st_d, st_q;

    logic signed [ACC_W-1:0] cb_w, cr_w;
    logic signed [ACC_W-1:0] acc_r, acc_g, acc_b;
    logic signed [ACC_W-1:0] sh_r, sh_g, sh_b;

    always_comb begin
        cb_w  = cbs_i;
        cr_w  = crs_i;
        acc_r = cr_w * K_CR_TO_R + HALF_RB;
        acc_g = cb_w * K_CB_TO_G + cr_w * K_CR_TO_G + HALF_G;
        acc_b = cb_w * K_CB_TO_B + HALF_RB;
        sh_r  = acc_r >>> SH_RB;
        sh_g  = acc_g >>> SH_G;
        sh_b  = acc_b >>> SH_RB;

        st_d = st_q;
        if (adv_i) begin
            st_d.valid = valid_i;
            st_d.y     = y_i;
            st_d.r_off = sh_r[OFF_W-1:0];
            st_d.g_off = sh_g[OFF_W-1:0];
            st_d.b_off = sh_b[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign y_o     = st_q.y;
    assign r_off_o = st_q.r_off;
    assign g_off_o = st_q.g_off;
    assign b_off_o = st_q.b_off;

    localparam logic signed [OFF_W-1:0] R_LO = OFF_W'(-179);
    localparam logic signed [OFF_W-1:0] R_HI = OFF_W'(178);
    localparam logic signed [OFF_W-1:0] G_LO = OFF_W'(-134);
    localparam logic signed [OFF_W-1:0] G_HI = OFF_W'(135);
    localparam logic signed [OFF_W-1:0] B_LO = OFF_W'(-227);
    localparam logic signed [OFF_W-1:0] B_HI = OFF_W'(225);

    AST_CENTRED_CHROMA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && valid_i && cbs_i == 0 && crs_i == 0) |=> (st_q.r_off == 0 && st_q.g_off == 0 && st_q.b_off == 0)); // R1
    AST_RED_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.r_off >= R_LO && st_q.r_off <= R_HI)); // R2
    AST_GREEN_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.g_off >= G_LO && st_q.g_off <= G_HI)); // R3
    AST_BLUE_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.b_off >= B_LO && st_q.b_off <= B_HI)); // R4

endmodule

// File: rtl/rgb_pack_stage.sv
module rgb_pack_stage
    import ycc2rgb_pkg::*;
#(
    parameter int PIX_W = PIXW,
    parameter int OFF_W = OFFW,
    parameter int FMT_W = FMTW,
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_i,
    input  logic [FMT_W-1:0]         fmt_i,
    input  logic                     valid_i,
    input  logic [PIX_W-1:0]         y_i,
    input  logic signed [OFF_W-1:0]  r_off_i,
    input  logic signed [OFF_W-1:0]  g_off_i,
    input  logic signed [OFF_W-1:0]  b_off_i,
    output logic                     valid_o,
    output logic [LANES*PIX_W-1:0]   pix_o
);
    localparam int WORD_W = LANES * PIX_W;
    localparam logic signed [OFF_W-1:0] TOP = OFF_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic               valid;
        logic [FMT_W-1:0]   fmt;
        logic [WORD_W-1:0]  pix;
    } pack_t;

    pack_t st_d, st_q;

    logic signed [OFF_W-1:0] off_a [3];
    logic [PIX_W-1:0]        chan  [3];
    logic [WORD_W-1:0]       word_w;

    assign off_a[0] = r_off_i;
    assign off_a[1] = g_off_i;
    assign off_a[2] = b_off_i;

    // Per-channel add and saturate.
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        logic signed [OFF_W-1:0] sum;
        always_comb begin
            sum = $signed({{(OFF_W-PIX_W){1'b0}}, y_i}) + off_a[ch];
            if (sum < 0)        chan[ch] = '0;
            else if (sum > TOP) chan[ch] = '1;
            else                chan[ch] = sum[PIX_W-1:0];
        end
    end

    // Per-lane byte placement.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [PIX_W-1:0] lane_v;
        always_comb begin
            case (lane_src(fmt_i, ln))
                SRC_R:    lane_v = chan[0];
                SRC_G:    lane_v = chan[1];
                SRC_B:    lane_v = chan[2];
                SRC_FILL: lane_v = '1;
                default:  lane_v = '0;
            endcase
        end
        assign word_w[ln*PIX_W +: PIX_W] = lane_v;
    end

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.valid = valid_i;
            st_d.fmt   = fmt_i;
            st_d.pix   = word_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign pix_o   = st_q.pix;

    AST_LOW_LANE_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && (st_q.fmt == FMT_XBGR || st_q.fmt == FMT_XRGB)) |-> (st_q.pix[PIX_W-1:0] == '1)); // R6
    AST_HIGH_LANE_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && (st_q.fmt == FMT_RGBX || st_q.fmt == FMT_BGRX || st_q.fmt > FMT_XRGB))
        |-> (st_q.pix[WORD_W-1 -: PIX_W] == '1)); // R6
    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && (st_q.fmt == FMT_RGB24 || st_q.fmt == FMT_BGR24)) |-> (st_q.pix[WORD_W-1 -: PIX_W] == '0)); // R7

endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
    import ycc2rgb_pkg::*;
#(
    parameter int PIX_W = PIXW,
    parameter int FMT_W = FMTW,
    parameter int ACC_W = ACCW,
    parameter int OFF_W = OFFW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FMT_W-1:0]   fmt_sel,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PIX_W-1:0]   in_y,
    input  logic [PIX_W-1:0]   in_cb,
    input  logic [PIX_W-1:0]   in_cr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [4*PIX_W-1:0] out_pix
);
    localparam int LANES = 4;

    typedef struct packed {
        logic [FMT_W-1:0] fmt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                    adv;
    logic                    busy;
    logic                    v1, v2, v3;
    logic [PIX_W-1:0]        y1, y2;
    logic signed [PIX_W:0]   cbs1, crs1;
    logic signed [OFF_W-1:0] r_off2, g_off2, b_off2;

    assign adv      = !v3 || out_ready;
    assign busy     = v1 || v2 || v3;
    assign in_ready = adv;

    always_comb begin
        ctl_d = ctl_q;
        if (!busy) ctl_d.fmt = fmt_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    ycc_bias_stage #(.PIX_W(PIX_W)) u_bias (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .valid_i (in_valid),
        .y_i     (in_y),
        .cb_i    (in_cb),
        .cr_i    (in_cr),
        .valid_o (v1),
        .y_o     (y1),
        .cbs_o   (cbs1),
        .crs_o   (crs1)
    );

    ycc_mac_stage #(.PIX_W(PIX_W), .ACC_W(ACC_W), .OFF_W(OFF_W)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .valid_i (v1),
        .y_i     (y1),
        .cbs_i   (cbs1),
        .crs_i   (crs1),
        .valid_o (v2),
        .y_o     (y2),
        .r_off_o (r_off2),
        .g_off_o (g_off2),
        .b_off_o (b_off2)
    );

    rgb_pack_stage #(.PIX_W(PIX_W), .OFF_W(OFF_W), .FMT_W(FMT_W), .LANES(LANES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .fmt_i   (ctl_q.fmt),
        .valid_i (v2),
        .y_i     (y2),
        .r_off_i (r_off2),
        .g_off_i (g_off2),
        .b_off_i (b_off2),
        .valid_o (v3),
        .pix_o   (out_pix)
    );

    assign out_valid = v3;

    AST_STALL_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R9
    AST_LAYOUT_FROZEN_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 || v2) |=> $stable(ctl_q.fmt)); // R10

endmodule

// File: tb/ycc2rgb_conv_tb.sv
`timescale 1ns/1ps
module ycc2rgb_conv_tb;
    import ycc2rgb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  fmt_sel;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_y, in_cb, in_cr;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_pix;

    always #2 clk = ~clk;

    ycc2rgb_conv u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          blocked = 0;
    bit          finished = 0;
    bit          bp_on = 0;
    bit          use_override = 0;
    logic [31:0] override_val;
    int          eff_fmt = 0;
    string       cur_tag = "R2 R3 R4";
    logic [31:0] exp_q[$];
    bit          prev_stall = 0;
    logic [31:0] prev_pix = '0;
    logic [31:0] lf = 32'h1234_5678;

    task automatic report_done();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [7:0] sat8(input int v);
        if (v < 0) return 8'h00;
        if (v > 255) return 8'hFF;
        return 8'(v);
    endfunction

    function automatic logic [31:0] ref_pix(input int y, input int cb, input int cr, input int fmt);
        int c_b, c_r;
        logic [7:0] r, g, b;
        c_b = cb - 128;
        c_r = cr - 128;
        r = sat8(y + ((c_r * 22971 + 8192) >>> 14));
        g = sat8(y + ((c_b * (-11277) + c_r * (-23401) + 16384) >>> 15));
        b = sat8(y + ((c_b * 29033 + 8192) >>> 14));
        case (fmt)
            0:       return {8'h00, b, g, r};
            1:       return {8'h00, r, g, b};
            3:       return {8'hFF, r, g, b};
            4:       return {r, g, b, 8'hFF};
            5:       return {b, g, r, 8'hFF};
            default: return {8'hFF, b, g, r};
        endcase
    endfunction

    task automatic rnd();
        lf ^= lf << 13;
        lf ^= lf >> 17;
        lf ^= lf << 5;
    endtask

    // Called at a falling edge with inputs set; books the transfers of the next rising edge.
    task automatic tick(output bit acc);
        logic [31:0] e;
        if (bp_on) begin
            rnd();
            out_ready = (lf[9:8] != 2'b00);
        end
        #1;
        if (prev_stall)
            chk(out_valid && out_pix == prev_pix, "R9 held word", out_pix, prev_pix);
        if (out_valid && !out_ready)
            chk(!in_ready, "R9 in_ready low", {31'b0, in_ready}, 32'h0);
        if (in_valid && !in_ready) blocked++;
        acc = in_valid && in_ready;
        if (acc) exp_q.push_back(use_override ? override_val : ref_pix(in_y, in_cb, in_cr, eff_fmt));
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected word", out_pix, 32'h0);
            else begin
                e = exp_q.pop_front();
                chk(out_pix == e, cur_tag, out_pix, e);
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pix;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        bit a;
        for (int i = 0; i < n; i++) tick(a);
    endtask

    task automatic send(input int y, input int cb, input int cr);
        bit a;
        in_valid = 1'b1;
        in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
        do tick(a); while (!a);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        bp_on = 0;
        out_ready = 1'b1;
        in_valid = 1'b0;
        while (exp_q.size() > 0) idle(1);
        idle(2);
    endtask

    task automatic set_fmt(input int f);
        drain();
        fmt_sel = 3'(f);
        eff_fmt = f;
        idle(2);
    endtask

    task automatic send_fixed(input int y, input int cb, input int cr, input logic [31:0] v, input string tag);
        cur_tag = tag;
        use_override = 1;
        override_val = v;
        send(y, cb, cr);
        use_override = 0;
        drain();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
        report_done();
    end

    initial begin
        rst_n = 1'b0; fmt_sel = 3'd0; in_valid = 1'b0;
        in_y = '0; in_cb = '0; in_cr = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11 out_valid in reset", {31'b0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R11 in_ready in reset", {31'b0, in_ready}, 32'h1);
        rst_n = 1'b1;
        idle(2);
        chk(out_valid == 1'b0, "R11 out_valid after reset", {31'b0, out_valid}, 32'h0);

        // Hand-computed points, layout 0
        set_fmt(0);
        send_fixed(100, 128, 128, 32'h0064_6464, "R1 neutral chroma");
        send_fixed(0, 128, 255, 32'h0000_00B2, "R2 red scale");
        send_fixed(0, 0, 0, 32'h0000_8700, "R3 green scale");
        send_fixed(0, 255, 128, 32'h00E1_0000, "R4 blue scale");
        send_fixed(255, 128, 255, 32'h00FF_A4FF, "R5 saturation");

        // Layout placement: Y=100 Cb=128 Cr=255 -> R=FF G=09 B=64
        set_fmt(1); send_fixed(100, 128, 255, 32'h00FF_0964, "R7 layout 1");
        set_fmt(0); send_fixed(100, 128, 255, 32'h0064_09FF, "R7 layout 0");
        set_fmt(2); send_fixed(100, 128, 255, 32'hFF64_09FF, "R6 layout 2");
        set_fmt(3); send_fixed(100, 128, 255, 32'hFFFF_0964, "R6 layout 3");
        set_fmt(4); send_fixed(100, 128, 255, 32'hFF09_64FF, "R6 layout 4");
        set_fmt(5); send_fixed(100, 128, 255, 32'h6409_FFFF, "R6 layout 5");
        set_fmt(6); send_fixed(100, 128, 255, 32'hFF64_09FF, "R6 layout 6");
        set_fmt(7); send_fixed(100, 128, 255, 32'hFF64_09FF, "R6 layout 7");

        // R8 latency through an empty pipeline
        set_fmt(0);
        cur_tag = "R8 latency word";
        in_valid = 1'b1; in_y = 8'd50; in_cb = 8'd90; in_cr = 8'd200;
        idle(1);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R8 after edge 1", {31'b0, out_valid}, 32'h0);
        idle(1);
        chk(out_valid == 1'b0, "R8 after edge 2", {31'b0, out_valid}, 32'h0);
        idle(1);
        chk(out_valid == 1'b1, "R8 after edge 3", {31'b0, out_valid}, 32'h1);
        drain();

        // R10 layout change with beats in flight, and R9 stall
        cur_tag = "R10 in-flight layout";
        out_ready = 1'b0;
        send(10, 20, 30);
        send(200, 250, 5);
        send(128, 60, 190);
        fmt_sel = 3'd5;
        idle(4);
        chk(exp_q.size() == 3, "R9 nothing lost in stall", 32'(exp_q.size()), 32'd3);
        drain();
        eff_fmt = 5;
        cur_tag = "R10 new layout";
        send(10, 20, 30);
        drain();

        // Full chroma grid in layout 0 at full rate
        set_fmt(0);
        cur_tag = "R2 R3 R4 R5 grid";
        blocked = 0;
        for (int cb = 0; cb < 256; cb++) begin
            for (int cr = 0; cr < 256; cr++) begin
                send((cb * 37 + cr * 11 + 5) & 255, cb, cr);
            end
        end
        chk(blocked == 0, "R8 full throughput", 32'(blocked), 32'h0);
        drain();

        // Every layout: extremes and random beats with backpressure
        for (int f = 0; f < 8; f++) begin
            set_fmt(f);
            cur_tag = (f < 2) ? "R7 R9 layout sweep" : "R6 R9 layout sweep";
            for (int k = 0; k < 8; k++) send((k & 1) * 255, ((k >> 1) & 1) * 255, ((k >> 2) & 1) * 255);
            bp_on = 1;
            for (int n = 0; n < 1200; n++) begin
                rnd();
                send(int'(lf[7:0]), int'(lf[15:8]), int'(lf[23:16]));
            end
            drain();
        end

        chk(exp_q.size() == 0, "R8 all words delivered", 32'(exp_q.size()), 32'h0);
        report_done();
    end

endmodule